// File: doc/BRIEF.md
# Halt and Wake-up Sequencer

This block decides when a small processor may sleep and how it comes back. When the core signals a halt, the sequencer gates the system clock off and holds the core stalled. Register and pin state stay as they are. The sequencer runs on an always-on clock. In that domain it watches four wake sources: an external reset, a watchdog overflow, interrupt requests, and falling edges on enabled I/O pins.

When a wake is accepted, the clock is restored, but the core stays stalled for a fixed settling window of system-clock periods. At the end of that window the sequencer presents a resume action for the core to carry out. The action is one of: continue with the next instruction, take the interrupt, perform a warm reset (only the program counter and stack pointer are cleared), or perform a full reset.

Interrupt wakes depend on the interrupt enables and the stack. If an enabled, woken interrupt exists and the stack has room, the interrupt is taken; otherwise execution continues. An interrupt that was already requesting when the halt began can never wake the device during that halt.

Top module: `halt_wake_seq`

## Requirements
- R1: After reset the outputs are `sysClkEn`=1, `stall`=0 and `resumeValid`=0, and `resumeAction`=0.
- R2: When `haltReq` is high in the running state and `extRst` is low, from the next cycle onward `sysClkEn`=0 and `stall`=1. This holds until a wake is accepted.
- R3: On the edge that accepts a wake, the settling window begins. During the window `sysClkEn`=1 and `stall`=1 for exactly `SETTLE_CYCLES` (1024) cycles. `resumeValid` is high only in the last of those cycles. `resumeAction` holds the decided action from the accepting edge onward, encoded as 0 next instruction, 1 take interrupt, 2 warm reset, 3 full reset.
- R4: Port A pins form bits 0..`PA_W`-1 of the pin vector, and each pin has its own wake enable. The pins pass through a two-stage synchronizer. A high-to-low change relative to the previous synchronized value (first captured at halt entry) wakes the device with action 0. Rising edges and edges on disabled pins are ignored.
- R5: Each further port contributes `PORT_W` bits above port A, and each such port has one wake enable covering all its pins. A falling edge on any pin of an enabled port wakes the device with action 0.
- R6: A request line that is not barred wakes the device. The action is 1 if some such line has its enable set and `stackFull` is low; otherwise the action is 0.
- R7: A request line that is high on the halt-entry edge is barred from waking the device for the whole of that halt.
- R8: `wdtOvf` during halt wakes the device with action 2. While the core is running or settling, `wdtOvf` has no effect.
- R9: `extRst` in any state starts, or restarts, the settling window with action 3.
- R10: When several wake sources are present in the same halt cycle, the winner is chosen in this order: external reset, then watchdog, then interrupt, then pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| haltReq | input | 1 | Core requests halt |
| extRst | input | 1 | External reset request |
| wdtOvf | input | 1 | Watchdog overflow |
| irqReq | input | NUM_IRQ | Interrupt request flags |
| irqEn | input | NUM_IRQ | Interrupt enables |
| stackFull | input | 1 | Return stack has no free entry |
| portAPins | input | PA_W | Port A pin levels (asynchronous) |
| portAWakeEn | input | PA_W | Per-pin wake enables, port A |
| portPins | input | NUM_PORTS*PORT_W | Other ports' pin levels (asynchronous) |
| portWakeEn | input | NUM_PORTS | One wake enable per other port |
| sysClkEn | output | 1 | System clock enable |
| stall | output | 1 | Holds the core |
| resumeValid | output | 1 | Resume action is to be taken now |
| resumeAction | output | 2 | Decided resume action |

## Verification
The embedded assertions check every cycle that:
- a halt request turns the clock off on the next cycle;
- a halted core stays clock-gated until a wake hit;
- an external reset always lands in the settling window with the full-reset action;
- the settle counter stays within its window;
- the resume pulse lasts one cycle and releases the stall.

Other behaviour can only be shown by the bench's scenarios, run against a behavioural model that is compared every cycle. That includes the exact 1024-cycle window length, edge detection through the synchronizer delay, barring of pre-pending interrupts, the interrupt take-or-continue choice and the wake priority order.

// File: rtl/hws_pkg.sv
package hws_pkg;

  typedef enum logic [1:0] {
    RESUME_NEXT = 2'd0,
    RESUME_IRQ  = 2'd1,
    RESUME_WARM = 2'd2,
    RESUME_FULL = 2'd3
  } resume_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2
  } seq_state_e;

  // Strobes from control to the wake datapath
  typedef struct packed {
    logic captureHalt;  // snapshot pins and pending requests at halt entry
    logic trackPins;    // follow synchronized pins while halted
    logic startSettle;  // clear settle counter, latch decided action
    logic countStep;    // advance settle counter
  } strobe_t;

endpackage

// File: rtl/hws_sync.sv
module hws_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/hws_wake_path.sv
module hws_wake_path
  import hws_pkg::*;
#(
  parameter int NUM_IRQ       = 4,
  parameter int PA_W          = 8,
  parameter int NUM_PORTS     = 3,
  parameter int PORT_W        = 8,
  parameter int SETTLE_CYCLES = 1024,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             strobe,
  input  logic [PA_W+NUM_PORTS*PORT_W-1:0]    pinsRaw,
  input  logic [PA_W-1:0]                     portAWakeEn,
  input  logic [NUM_PORTS-1:0]                portWakeEn,
  input  logic [NUM_IRQ-1:0]                  irqReq,
  input  logic [NUM_IRQ-1:0]                  irqEn,
  input  logic                                stackFull,
  input  logic                                wdtOvf,
  input  logic                                extRst,
  output logic                                wakeHit,
  output logic                                settleLast,
  output resume_e                             resumeAction
);

  localparam int PIN_W = PA_W + NUM_PORTS * PORT_W;
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [PIN_W-1:0]   pinSync;
  logic [PIN_W-1:0]   pinMask;
  logic [PIN_W-1:0]   lastPins;
  logic [NUM_IRQ-1:0] blockedMask;
  logic [NUM_IRQ-1:0] irqLive;
  logic [CNT_W-1:0]   settleCnt;
  logic               fallHit;
  logic               irqWake;
  logic               irqTake;
  resume_e            wakeAction;

  hws_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) uPinSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinsRaw),
    .dout (pinSync)
  );

  // Port A: one enable per pin; other ports: one enable per port
  for (genvar b = 0; b < PA_W; b++) begin : g_portA
    assign pinMask[b] = portAWakeEn[b];
  end
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ports
    assign pinMask[PA_W + p*PORT_W +: PORT_W] = {PORT_W{portWakeEn[p]}};
  end

  assign fallHit = |(lastPins & ~pinSync & pinMask);
  assign irqLive = irqReq & ~blockedMask;
  assign irqWake = |irqLive;
  assign irqTake = (|(irqLive & irqEn)) && !stackFull;
  assign wakeHit = extRst || wdtOvf || irqWake || fallHit;

  // Fixed priority: external reset, watchdog, interrupt, pin
  always_comb begin
    if (extRst)       wakeAction = RESUME_FULL;
    else if (wdtOvf)  wakeAction = RESUME_WARM;
    else if (irqWake) wakeAction = irqTake ? RESUME_IRQ : RESUME_NEXT;
    else              wakeAction = RESUME_NEXT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastPins     <= '1;
      blockedMask  <= '0;
      settleCnt    <= '0;
      resumeAction <= RESUME_NEXT;
    end else begin
      if (strobe.captureHalt || strobe.trackPins) lastPins <= pinSync;
      if (strobe.captureHalt) blockedMask <= irqReq;
      if (strobe.startSettle) begin
        settleCnt    <= '0;
        resumeAction <= wakeAction;
      end else if (strobe.countStep) begin
        settleCnt <= settleCnt + CNT_W'(1);
      end
    end
  end

  assign settleLast = (settleCnt == CNT_LAST);

  // R3: the settle counter never runs past the window
  assert_settle_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countStep |-> (settleCnt != CNT_LAST));

endmodule

// File: rtl/hws_ctrl.sv
module hws_ctrl
  import hws_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    haltReq,
  input  logic    extRst,
  input  logic    wakeHit,
  input  logic    settleLast,
  output strobe_t strobe,
  output logic    sysClkEn,
  output logic    stall,
  output logic    resumeValid
);

  seq_state_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_RUN: begin
        if (extRst) begin
          strobe.startSettle = 1'b1;
          stateNext          = ST_SETTLE;
        end else if (haltReq) begin
          strobe.captureHalt = 1'b1;
          stateNext          = ST_HALT;
        end
      end
      ST_HALT: begin
        strobe.trackPins = 1'b1;
        if (wakeHit) begin
          strobe.startSettle = 1'b1;
          stateNext          = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (extRst)          strobe.startSettle = 1'b1;
        else if (settleLast) stateNext = ST_RUN;
        else                 strobe.countStep = 1'b1;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign sysClkEn    = (state != ST_HALT);
  assign stall       = (state != ST_RUN);
  assign resumeValid = (state == ST_SETTLE) && settleLast && !extRst;

  // R2: a halt request gates the clock on the following cycle
  assert_halt_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && haltReq && !extRst) |=> (!sysClkEn && stall));

  // R2: without a wake hit a halted core stays gated
  assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!sysClkEn && !wakeHit) |=> !sysClkEn);

  // R3: resume pulse is single and releases the stall
  assert_resume_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |=> (!stall && !resumeValid && sysClkEn));

endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
  import hws_pkg::*;
#(
  parameter int NUM_IRQ       = 4,
  parameter int PA_W          = 8,
  parameter int NUM_PORTS     = 3,
  parameter int PORT_W        = 8,
  parameter int SETTLE_CYCLES = 1024,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        haltReq,
  input  logic                        extRst,
  input  logic                        wdtOvf,
  input  logic [NUM_IRQ-1:0]          irqReq,
  input  logic [NUM_IRQ-1:0]          irqEn,
  input  logic                        stackFull,
  input  logic [PA_W-1:0]             portAPins,
  input  logic [PA_W-1:0]             portAWakeEn,
  input  logic [NUM_PORTS*PORT_W-1:0] portPins,
  input  logic [NUM_PORTS-1:0]        portWakeEn,
  output logic                        sysClkEn,
  output logic                        stall,
  output logic                        resumeValid,
  output logic [1:0]                  resumeAction
);

  strobe_t strobe;
  logic    wakeHit;
  logic    settleLast;
  resume_e actionQ;

  hws_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .haltReq     (haltReq),
    .extRst      (extRst),
    .wakeHit     (wakeHit),
    .settleLast  (settleLast),
    .strobe      (strobe),
    .sysClkEn    (sysClkEn),
    .stall       (stall),
    .resumeValid (resumeValid)
  );

  hws_wake_path #(
    .NUM_IRQ       (NUM_IRQ),
    .PA_W          (PA_W),
    .NUM_PORTS     (NUM_PORTS),
    .PORT_W        (PORT_W),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .pinsRaw      ({portPins, portAPins}),
    .portAWakeEn  (portAWakeEn),
    .portWakeEn   (portWakeEn),
    .irqReq       (irqReq),
    .irqEn        (irqEn),
    .stackFull    (stackFull),
    .wdtOvf       (wdtOvf),
    .extRst       (extRst),
    .wakeHit      (wakeHit),
    .settleLast   (settleLast),
    .resumeAction (actionQ)
  );

  assign resumeAction = actionQ;

  // R9: external reset always lands in the window with the full-reset action
  assert_ext_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    extRst |=> (stall && sysClkEn && resumeAction == 2'd3));

endmodule

// File: tb/halt_wake_seq_test.sv
`timescale 1ns/1ps
module halt_wake_seq_test;

  localparam int NI  = 4;
  localparam int PAW = 8;
  localparam int NP  = 3;
  localparam int PW  = 8;
  localparam int SET = 1024;
  localparam int PIN = PAW + NP*PW;

  logic clk = 0;
  logic rstN = 0;
  logic haltReq = 0, extRst = 0, wdtOvf = 0, stackFull = 0;
  logic [NI-1:0] irqReq = '0, irqEn = '0;
  logic [PAW-1:0] portAPins = '1, portAWakeEn = '0;
  logic [NP*PW-1:0] portPins = '1;
  logic [NP-1:0] portWakeEn = '0;
  logic sysClkEn, stall, resumeValid;
  logic [1:0] resumeAction;

  halt_wake_seq uut (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .extRst(extRst), .wdtOvf(wdtOvf),
    .irqReq(irqReq), .irqEn(irqEn), .stackFull(stackFull),
    .portAPins(portAPins), .portAWakeEn(portAWakeEn),
    .portPins(portPins), .portWakeEn(portWakeEn),
    .sysClkEn(sysClkEn), .stall(stall), .resumeValid(resumeValid),
    .resumeAction(resumeAction)
  );

  always #5 clk = ~clk;

  int vecs = 0, errs = 0;
  bit done = 0;
  string curReq = "R1";

  // Behavioural reference: 0 run, 1 halted, 2 settling
  int mMode, mCnt, mAct;
  logic [PIN-1:0] mLast;
  logic [NI-1:0] mBlocked;
  logic [PIN-1:0] pinQ[$];

  function automatic logic [PIN-1:0] enMask();
    logic [PIN-1:0] m;
    for (int i = 0; i < PIN; i++)
      m[i] = (i < PAW) ? portAWakeEn[i] : portWakeEn[(i-PAW)/PW];
    return m;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mCnt = 0; mAct = 0; mLast = '1; mBlocked = '0;
      pinQ = {};
      pinQ.push_back('1); pinQ.push_back('1);
    end else begin
      logic [PIN-1:0] seen;
      logic [NI-1:0] live;
      seen = pinQ[0];
      void'(pinQ.pop_front());
      pinQ.push_back({portPins, portAPins});
      live = irqReq & ~mBlocked;
      case (mMode)
        0: if (extRst) begin mMode = 2; mCnt = 0; mAct = 3; end
           else if (haltReq) begin mMode = 1; mLast = seen; mBlocked = irqReq; end
        1: begin
          logic fell;
          fell = |(mLast & ~seen & enMask());
          if (extRst)      begin mMode = 2; mCnt = 0; mAct = 3; end
          else if (wdtOvf) begin mMode = 2; mCnt = 0; mAct = 2; end
          else if (live != 0) begin
            mMode = 2; mCnt = 0;
            mAct = ((live & irqEn) != 0 && !stackFull) ? 1 : 0;
          end
          else if (fell) begin mMode = 2; mCnt = 0; mAct = 0; end
          mLast = seen;
        end
        default: if (extRst) begin mCnt = 0; mAct = 3; end
                 else if (mCnt == SET-1) mMode = 0;
                 else mCnt++;
      endcase
    end
  end

  task automatic compare();
    logic eEn, eSt, eVal;
    eEn  = (mMode != 1);
    eSt  = (mMode != 0);
    eVal = (mMode == 2) && (mCnt == SET-1) && !extRst;
    vecs++;
    if (sysClkEn !== eEn || stall !== eSt || resumeValid !== eVal ||
        resumeAction !== 2'(mAct)) begin
      errs++;
      $display("FAIL %s t=%0t en/stall/valid/act = %b%b%b/%0d expected %b%b%b/%0d",
               curReq, $time, sysClkEn, stall, resumeValid, resumeAction,
               eEn, eSt, eVal, mAct);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      compare();
    end
  endtask

  task automatic doHalt();
    haltReq = 1; tick(1); haltReq = 0; tick(4);
  endtask

  task automatic finishSettle();
    tick(SET + 4);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    #1;
    curReq = "R1"; compare();
    #20 rstN = 1;
    tick(3);

    // R2 + R4: enabled port A pin falls during halt
    curReq = "R4"; portAWakeEn = 8'h04;
    doHalt(); tick(10);
    portAPins[2] = 0; tick(6); finishSettle();
    portAPins[2] = 1; tick(4);

    // R4: disabled pin and rising edge ignored, then R8 watchdog wakes
    curReq = "R4"; portAPins[5] = 0; tick(4);
    doHalt();
    portAPins[3] = 0; tick(8);
    portAPins[5] = 1; tick(8);
    curReq = "R8"; wdtOvf = 1; tick(1); wdtOvf = 0; finishSettle();
    portAPins = '1; tick(4);

    // R5: other port, per-port enable
    curReq = "R5"; portWakeEn = 3'b010;
    doHalt();
    portPins[3] = 0; tick(8);           // port 0 disabled
    portPins[PW + 6] = 0; tick(6); finishSettle();
    portPins = '1; portWakeEn = '0; tick(4);

    // R6: enabled interrupt, stack free -> take interrupt
    curReq = "R6"; irqEn = 4'b0011;
    doHalt(); irqReq[1] = 1; tick(1); irqReq = '0; finishSettle();
    // R6: stack full -> next instruction
    stackFull = 1; doHalt(); irqReq[0] = 1; tick(1); irqReq = '0; finishSettle();
    stackFull = 0;
    // R6: disabled interrupt still wakes -> next instruction
    doHalt(); irqReq[3] = 1; tick(1); irqReq = '0; finishSettle();

    // R7: request pending at halt entry cannot wake
    curReq = "R7"; irqReq[0] = 1; tick(2);
    doHalt(); tick(30);
    irqReq[1] = 1; tick(1); irqReq = '0; finishSettle();

    // R8: watchdog ignored while running and while settling
    curReq = "R8"; wdtOvf = 1; tick(3); wdtOvf = 0;
    doHalt(); portAWakeEn = 8'h01; portAPins[0] = 0; tick(8);
    wdtOvf = 1; tick(2); wdtOvf = 0; finishSettle();
    portAPins = '1; portAWakeEn = '0; tick(4);

    // R10 + R9: external reset beats watchdog and interrupt
    curReq = "R10"; doHalt();
    extRst = 1; wdtOvf = 1; irqReq[1] = 1; tick(1);
    extRst = 0; wdtOvf = 0; irqReq = '0; finishSettle();
    // R10: watchdog beats interrupt
    doHalt(); wdtOvf = 1; irqReq[1] = 1; tick(1);
    wdtOvf = 0; irqReq = '0; finishSettle();
    // R10: interrupt beats pin
    portAWakeEn = 8'h80; doHalt(); portAPins[7] = 0; tick(2);
    irqReq[0] = 1; tick(1); irqReq = '0; finishSettle();
    portAPins = '1; portAWakeEn = '0; tick(4);

    // R9: external reset while running and restarting a window
    curReq = "R9"; extRst = 1; tick(1); extRst = 0; tick(500);
    extRst = 1; tick(1); extRst = 0; tick(SET - 2);
    extRst = 1; tick(1); extRst = 0; finishSettle();

    // R3: halt/wake round trip with long quiet halt
    curReq = "R3"; irqEn = '1; doHalt(); tick(200);
    irqReq[2] = 1; tick(1); irqReq = '0; finishSettle();

    summary();
  end

endmodule